// File: doc/BRIEF.md
# Trimmed-Mean Cell Voltage Averager

This block turns a short burst of ADC conversions for one cell voltage into a single millivolt reading. A one-cycle start pulse in the idle state begins a burst. The block raises a conversion request and accepts samples whenever the ADC returns one with a valid strobe. While the burst runs it keeps a running total, a running minimum and a running maximum. After six samples it removes one smallest and one largest value and adds the four that remain.

A range-select input is captured when the burst starts. In normal range the trimmed sum of four 10-bit samples is already the reading in millivolts. In expanded range the front end covers 2048 to 4095 mV at 2 mV per count. The block halves the trimmed sum and adds 2048, so the output still reads directly in millivolts. The result appears with a one-cycle done pulse and stays on the output until the next done pulse.

The control has three states. `ST_IDLE` waits for start. `ST_ACQUIRE` requests and collects the samples. `ST_REPORT` lasts one cycle and publishes the result. The transitions are:

- IDLE→ACQUIRE when start is seen.
- ACQUIRE→REPORT when the sixth sample is accepted.
- REPORT→IDLE unconditionally.

Top module: `trim_mean_avg`

## Requirements
- R1: While reset is held and just after it is released, `conv_req_o` and `done_o` are 0 and `result_o` is 0.
- R2: A start pulse in `ST_IDLE` moves the block to `ST_ACQUIRE`. `conv_req_o` is 1 from the next cycle until the cycle in which the sixth sample is accepted.
- R3: A sample is accepted only on a clock edge where both `conv_req_o` and `smp_valid_i` are 1. A valid strobe outside a burst changes neither `result_o` nor `done_o`.
- R4: `done_o` is high for exactly one cycle, the cycle right after the edge that accepts the sixth sample.
- R5: In normal range (`wide_range_i` = 0), `result_o` equals the sum of the six samples minus one minimum and one maximum.
- R6: When several samples share the minimum or the maximum value, only one copy of each is removed. For example, six equal samples v give 4·v.
- R7: In expanded range (`wide_range_i` = 1), `result_o` equals (trimmed sum >> 1) + 2048.
- R8: `wide_range_i` is sampled on the start cycle only. Changes during the burst do not affect the result.
- R9: A start pulse during `ST_ACQUIRE` or `ST_REPORT` is ignored. It neither restarts the count nor clears the collected samples.
- R10: `result_o` never exceeds 4095 (it saturates). It keeps its value from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a measurement burst |
| wide_range_i | input | 1 | 1 = expanded range, captured at start |
| smp_valid_i | input | 1 | ADC sample strobe |
| smp_data_i | input | 10 | ADC sample value |
| conv_req_o | output | 1 | Conversion request to the ADC during a burst |
| result_o | output | 12 | Reading in millivolts |
| done_o | output | 1 | One-cycle pulse when `result_o` is new |

## Verification
The assertions assume these input conditions:

- The inputs are free of X after reset.
- The ADC returns a sample only while the request is high.
- `smp_data_i` stays within 10 bits, so the trimmed sum fits the result width.

The stimulus drives every input on the falling edge and raises the valid strobe only after seeing the request asserted. It inserts random idle gaps between samples. On purpose, it also sends stray strobes in idle, start pulses in mid-burst and range changes in mid-burst. These exercise the ignore rules without breaking the conditions above.

// File: rtl/trm_pkg.sv
package trm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACQUIRE = 2'd1,
        ST_REPORT  = 2'd2
    } trm_state_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import trm_pkg::*;
#(
    parameter int NUM_SAMPLES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       wide_i,
    input  logic       smp_valid_i,
    output trm_state_t state_o,
    output logic       clear_o,
    output logic       accept_o,
    output logic       wide_q_o,
    output logic       conv_req_o,
    output logic       done_o
);
    localparam int CNT_W = $clog2(NUM_SAMPLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_SAMPLES - 1);

    trm_state_t       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             wide_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_ACQUIRE;
            ST_ACQUIRE: if (accept_o && count_q == LAST) state_d = ST_REPORT;
            ST_REPORT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        clear_o    = 1'b0;
        conv_req_o = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:    clear_o    = start_i;
            ST_ACQUIRE: conv_req_o = 1'b1;
            ST_REPORT:  done_o     = 1'b1;
            default:    ;
        endcase
    end

    assign accept_o = conv_req_o && smp_valid_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            wide_q  <= 1'b0;
        end else if (clear_o) begin
            count_q <= '0;
            wide_q  <= wide_i;
        end else if (accept_o) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign state_o  = state_q;
    assign wide_q_o = wide_q;

    // R4
    report_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPORT) |-> $past(accept_o && count_q == LAST));
    // R4
    report_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPORT) |=> (state_q == ST_IDLE));
    // R8
    range_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQUIRE && $past(state_q == ST_ACQUIRE)) |-> $stable(wide_q));
    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQUIRE && start_i && !accept_o) |=> (state_q == ST_ACQUIRE && $stable(count_q)));
    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQUIRE) |-> (count_q <= LAST));
endmodule

// File: rtl/sample_tracker.sv
module sample_tracker #(
    parameter int SAMPLE_W    = 10,
    parameter int NUM_SAMPLES = 6
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     clear_i,
    input  logic                                     accept_i,
    input  logic [SAMPLE_W-1:0]                      data_i,
    output logic [SAMPLE_W-1:0]                      min_o,
    output logic [SAMPLE_W-1:0]                      max_o,
    output logic [SAMPLE_W+$clog2(NUM_SAMPLES)-1:0]  total_o
);
    localparam int SUM_W = SAMPLE_W + $clog2(NUM_SAMPLES);

    logic [SAMPLE_W-1:0] min_q, max_q;
    logic [SUM_W-1:0]    total_q;

    // strict compares keep the first copy on a tie; only one copy is removed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_q   <= '0;
            max_q   <= '0;
            total_q <= '0;
        end else if (clear_i) begin
            min_q   <= '1;
            max_q   <= '0;
            total_q <= '0;
        end else if (accept_i) begin
            if (data_i < min_q) min_q <= data_i;
            if (data_i > max_q) max_q <= data_i;
            total_q <= total_q + SUM_W'(data_i);
        end
    end

    assign min_o   = min_q;
    assign max_o   = max_q;
    assign total_o = total_q;

    // R5
    total_covers_extremes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && $past(accept_i && !clear_i)) |-> (total_q >= SUM_W'(max_q)));
endmodule

// File: rtl/result_scaler.sv
module result_scaler #(
    parameter int SAMPLE_W    = 10,
    parameter int NUM_SAMPLES = 6,
    parameter int RESULT_W    = 12
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     load_i,
    input  logic                                     wide_i,
    input  logic [SAMPLE_W+$clog2(NUM_SAMPLES)-1:0]  total_i,
    input  logic [SAMPLE_W-1:0]                      min_i,
    input  logic [SAMPLE_W-1:0]                      max_i,
    output logic [RESULT_W-1:0]                      result_o
);
    localparam int SUM_W = SAMPLE_W + $clog2(NUM_SAMPLES);
    localparam int CALC_W = (SUM_W > RESULT_W ? SUM_W : RESULT_W) + 1;
    localparam logic [CALC_W-1:0] OFFSET  = CALC_W'(1) << (RESULT_W - 1);
    localparam logic [CALC_W-1:0] SAT_MAX = (CALC_W'(1) << RESULT_W) - 1'b1;

    logic [CALC_W-1:0]   trimmed, scaled;
    logic [RESULT_W-1:0] calc, held_q;

    always_comb begin
        trimmed = CALC_W'(total_i) - CALC_W'(min_i) - CALC_W'(max_i);
        scaled  = wide_i ? ((trimmed >> 1) + OFFSET) : trimmed;
        calc    = (scaled > SAT_MAX) ? SAT_MAX[RESULT_W-1:0] : scaled[RESULT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held_q <= '0;
        else if (load_i) held_q <= calc;
    end

    assign result_o = load_i ? calc : held_q;

    // R7
    wide_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && wide_i) |-> (result_o >= OFFSET[RESULT_W-1:0]));
    // R10
    held_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !$past(load_i)) |-> $stable(result_o));
endmodule

// File: rtl/trim_mean_avg.sv
module trim_mean_avg
    import trm_pkg::*;
#(
    parameter int SAMPLE_W    = 10,
    parameter int NUM_SAMPLES = 6,
    parameter int RESULT_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                wide_range_i,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    output logic                conv_req_o,
    output logic [RESULT_W-1:0] result_o,
    output logic                done_o
);
    localparam int SUM_W = SAMPLE_W + $clog2(NUM_SAMPLES);

    trm_state_t          state;
    logic                clear, accept, wide_q;
    logic [SAMPLE_W-1:0] min_v, max_v;
    logic [SUM_W-1:0]    total_v;

    burst_ctrl #(.NUM_SAMPLES(NUM_SAMPLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_range_i),
        .smp_valid_i(smp_valid_i), .state_o(state), .clear_o(clear),
        .accept_o(accept), .wide_q_o(wide_q), .conv_req_o(conv_req_o),
        .done_o(done_o)
    );

    sample_tracker #(.SAMPLE_W(SAMPLE_W), .NUM_SAMPLES(NUM_SAMPLES)) u_track (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .accept_i(accept),
        .data_i(smp_data_i), .min_o(min_v), .max_o(max_v), .total_o(total_v)
    );

    result_scaler #(.SAMPLE_W(SAMPLE_W), .NUM_SAMPLES(NUM_SAMPLES), .RESULT_W(RESULT_W)) u_scale (
        .clk(clk), .rst_n(rst_n), .load_i(done_o), .wide_i(wide_q),
        .total_i(total_v), .min_i(min_v), .max_i(max_v), .result_o(result_o)
    );

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R3
    req_idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !conv_req_o);
    // R5
    trim_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (min_v <= max_v));
endmodule

// File: tb/sim_trim_mean_avg.sv
module sim_trim_mean_avg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       wide_range_i = 1'b0;
    logic       smp_valid_i = 1'b0;
    logic [9:0] smp_data_i = '0;
    logic       conv_req_o;
    logic [11:0] result_o;
    logic       done_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [9:0] s [6];

    always #5 clk = ~clk;

    trim_mean_avg u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_range_i(wide_range_i),
        .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .conv_req_o(conv_req_o),
        .result_o(result_o), .done_o(done_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000) begin
            n_fail++;
            $display("FAIL watchdog (R2) actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int expect_mv(input logic w);
        int sum = 0, mn = 1023, mx = 0, t;
        for (int i = 0; i < 6; i++) begin
            sum += s[i];
            if (s[i] < mn) mn = s[i];
            if (s[i] > mx) mx = s[i];
        end
        t = sum - mn - mx;
        if (w) t = (t >> 1) + 2048;
        if (t > 4095) t = 4095;
        return t;
    endfunction

    // flip: toggle range mid burst; restart: pulse start mid burst
    task automatic burst(input logic w, input bit flip, input bit restart, input bit gaps, input string tag);
        int exp;
        exp = expect_mv(w);
        @(negedge clk);
        start_i = 1'b1; wide_range_i = w;
        @(negedge clk);
        start_i = 1'b0;
        check(conv_req_o, 1, {tag, " R2 request"});
        for (int i = 0; i < 6; i++) begin
            if (gaps) begin
                for (int g = 0; g < int'($urandom_range(2)); g++) begin
                    smp_valid_i = 1'b0;
                    @(negedge clk);
                end
            end
            if (flip) wide_range_i = ~w;
            start_i = restart && (i == 3);
            smp_valid_i = 1'b1; smp_data_i = s[i];
            @(negedge clk);
            if (i < 5) check(done_o, 0, {tag, " R4 early done"});
        end
        smp_valid_i = 1'b0; start_i = 1'b0;
        check(done_o, 1, {tag, " R4 done"});
        check(conv_req_o, 0, {tag, " R2 request drop"});
        check(result_o, exp, {tag, " R5/R7 result"});
        @(negedge clk);
        check(done_o, 0, {tag, " R4 single pulse"});
        check(result_o, exp, {tag, " R10 held"});
    endtask

    initial begin
        void'($urandom(32'd2024));
        #1;
        check(conv_req_o, 0, "R1 req");
        check(done_o, 0, "R1 done");
        check(result_o, 0, "R1 result");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(conv_req_o, 0, "R1 req after release");

        s = '{100, 200, 300, 400, 500, 600};
        burst(1'b0, 0, 0, 0, "R5 ramp");
        s = '{500, 500, 500, 500, 500, 500};
        burst(1'b0, 0, 0, 0, "R6 all equal");
        s = '{7, 7, 900, 900, 300, 12};
        burst(1'b0, 0, 0, 1, "R6 dup extremes");
        s = '{1023, 1023, 1023, 1023, 1023, 1023};
        burst(1'b0, 0, 0, 0, "R10 full scale");
        burst(1'b1, 0, 0, 0, "R7 full scale wide");
        s = '{0, 0, 0, 0, 0, 0};
        burst(1'b1, 0, 0, 0, "R7 zero wide");
        s = '{11, 22, 33, 44, 55, 66};
        burst(1'b1, 1, 0, 1, "R8 flip to narrow");
        burst(1'b0, 1, 0, 0, "R8 flip to wide");
        s = '{250, 260, 270, 280, 290, 1000};
        burst(1'b0, 0, 1, 1, "R9 restart ignored");

        // R3: stray strobes in idle leave the outputs alone
        for (int k = 0; k < 4; k++) begin
            smp_valid_i = 1'b1; smp_data_i = 10'($urandom);
            @(negedge clk);
            check(done_o, 0, "R3 stray done");
            check(result_o, expect_mv(1'b0), "R3 stray result");
            check(conv_req_o, 0, "R3 stray req");
        end
        smp_valid_i = 1'b0;

        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < 6; i++) s[i] = 10'($urandom);
            burst(1'($urandom), bit'($urandom), bit'($urandom), 1, "R5/R7 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule